// File: doc/BRIEF.md
# Iterative Integer Divider with Overflow Detection

This block divides two 64-bit integers by shift and subtract. It produces one quotient bit per clock. It returns either the quotient or the remainder. Operands can be signed or unsigned, and the block works on the full word or on the low half-word. In extended mode the first operand is shifted left by the working width before the division, so the low half of the dividend is zero.

A single-cycle `start` pulse captures the operands and the mode flags. The block then runs one iteration for each result bit, plus one more iteration that yields a quotient bit of weight 2^W. That top bit marks every case where the quotient cannot be represented, and division by zero falls into this set. A range check in the finishing stage covers the signed and half-word limits. In any of these cases the result is zero and the condition word reports "equal".

The result word, the condition word, the valid flag and both write enables leave through one output register. The valid flag is a single-cycle pulse.

Top module: `iter_divider`

## Requirements
- R1: An unsigned division returns floor(dividend / divisor) when the quotient bit is selected (`rem_op`=0), and dividend mod divisor when the remainder is selected (`rem_op`=1).
- R2: A signed division truncates toward zero. The quotient is negative when the operand signs differ, and the remainder carries the sign of the dividend.
- R3: When `ext_op`=1, the dividend is the (magnitude of the) first operand shifted left by the working width: 64 bits in full mode, 32 bits in half mode.
- R4: When the divisor is zero, or dividend >= 2^64 × divisor, `res_out` is 0 and `crf_out` is 32'h2000_0000.
- R5: A quotient outside the representable range also gives result 0 and condition 32'h2000_0000. The range is [0, 2^w−1] for unsigned and [−2^(w−1), 2^(w−1)−1] for signed, where w is 32 when `half_op`=1 and 64 otherwise.
- R6: For a half-word signed quotient, bits 63:32 of the result are zero. The condition word is taken from the 64-bit result, so it is never 32'h8000_0000.
- R7: For a half-word signed remainder, bits 63:32 are a copy of bit 31, so a negative remainder has ones in the upper half.
- R8: The condition word is 32'h8000_0000 if result bit 63 is set, 32'h2000_0000 if the result is zero, and 32'h4000_0000 otherwise. Exactly one of these three bits is set.
- R9: `res_wen` is high together with `res_valid`. `crf_wen` is high with `res_valid` only when `rec_op`=1 and `rem_op`=0 were captured at start.
- R10: `res_valid` is a one-cycle pulse, W+2 clock edges after the edge that accepted `start`.
- R11: A `start` that arrives from the accepting edge up to and including the edge that raises `res_valid` is ignored. It does not change the pending result.
- R12: While `rst` is high, and after it falls, `res_valid`, `res_wen` and `crf_wen` are low and `res_out` is zero until a result is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division with the present operands and flags |
| opa | input | 64 | Dividend operand |
| opb | input | 64 | Divisor operand |
| sgn_op | input | 1 | Treat operands as two's complement |
| half_op | input | 1 | Use only the low 32 bits of each operand |
| ext_op | input | 1 | Extended dividend (operand shifted left by the width) |
| rem_op | input | 1 | Return remainder instead of quotient |
| rec_op | input | 1 | Request a condition-word update |
| res_out | output | 64 | Registered result word |
| crf_out | output | 32 | Registered condition word |
| res_valid | output | 1 | One-cycle result strobe |
| res_wen | output | 1 | Result write enable |
| crf_wen | output | 1 | Condition-word write enable |

## Verification
A corrupted partial remainder or a misaligned quotient shift shows up as a wrong result word, only at the valid pulse W+2 cycles after start. An error in the overflow bit shows up as a zero result with "equal" where a value was expected, or the reverse. A wrong iteration count moves or removes the valid pulse. The reference comparison on every clock catches this in the first cycle it happens. Captured mode flags that are overwritten by a second start during a run show up at the next result as a different value or a different condition enable.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  localparam int CRW = 32;
  localparam logic [CRW-1:0] CRF_LT = 32'h8000_0000;
  localparam logic [CRW-1:0] CRF_GT = 32'h4000_0000;
  localparam logic [CRW-1:0] CRF_EQ = 32'h2000_0000;

  typedef struct packed {
    logic sgn;
    logic half;
    logic ext;
    logic rem;
    logic rec;
  } idiv_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } idiv_state_t;
endpackage

// File: rtl/idiv_prep.sv
module idiv_prep
  import idiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  idiv_mode_t     mode,
  output logic [2*W-1:0] dvd,
  output logic [W-1:0]   dvs,
  output logic           neg_q,
  output logic           neg_r
);
  localparam int HW = W / 2;

  logic [W-1:0]   ea, eb, ma, mb;
  logic           sa, sb;
  logic [2*W-1:0] wide;

  always_comb begin
    if (mode.half) begin
      ea = mode.sgn ? {{HW{opa[HW-1]}}, opa[HW-1:0]} : {{HW{1'b0}}, opa[HW-1:0]};
      eb = mode.sgn ? {{HW{opb[HW-1]}}, opb[HW-1:0]} : {{HW{1'b0}}, opb[HW-1:0]};
    end else begin
      ea = opa;
      eb = opb;
    end
    sa   = mode.sgn & ea[W-1];
    sb   = mode.sgn & eb[W-1];
    ma   = sa ? (~ea + 1'b1) : ea;
    mb   = sb ? (~eb + 1'b1) : eb;
    wide = {{W{1'b0}}, ma};
    if (mode.ext) dvd = mode.half ? (wide << HW) : (wide << W);
    else          dvd = wide;
    dvs   = mb;
    neg_q = sa ^ sb;
    neg_r = sa;
  end
endmodule

// File: rtl/idiv_core.sv
module idiv_core #(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] dvd,
  input  logic [W-1:0]   dvs,
  output logic [W:0]     quo,
  output logic [W-1:0]   rmd
);
  logic [W-1:0] part;
  logic [W:0]   low;
  logic [W-1:0] dsr;
  logic [W:0]   trial, diff;
  logic         ge;

  always_comb begin
    trial = {part, low[W]};
    ge    = trial >= {1'b0, dsr};
    diff  = trial - {1'b0, dsr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      part <= '0;
      low  <= '0;
      dsr  <= '0;
      quo  <= '0;
    end else if (load) begin
      part <= {1'b0, dvd[2*W-1:W+1]};
      low  <= dvd[W:0];
      dsr  <= dvs;
      quo  <= '0;
    end else if (step) begin
      part <= ge ? diff[W-1:0] : trial[W-1:0];
      low  <= {low[W-1:0], 1'b0};
      quo  <= {quo[W-1:0], ge};
    end
  end

  assign rmd = part;
endmodule

// File: rtl/idiv_post.sv
module idiv_post
  import idiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W:0]     quo,
  input  logic [W-1:0]   rmd,
  input  idiv_mode_t     mode,
  input  logic           neg_q,
  input  logic           neg_r,
  output logic [W-1:0]   res,
  output logic [CRW-1:0] crw
);
  localparam int HW = W / 2;

  logic [W-1:0] q, qs, rs, val;
  logic         fits, bad;

  always_comb begin
    q  = quo[W-1:0];
    qs = neg_q ? (~q + 1'b1) : q;
    rs = neg_r ? (~rmd + 1'b1) : rmd;

    if (mode.rem) begin
      fits = 1'b1;
    end else if (mode.half) begin
      if (mode.sgn)
        fits = (q[W-1:HW] == '0) &&
               (neg_q ? (!q[HW-1] || (q[HW-2:0] == '0)) : !q[HW-1]);
      else
        fits = (q[W-1:HW] == '0);
    end else if (mode.sgn) begin
      fits = neg_q ? (!q[W-1] || (q[W-2:0] == '0)) : !q[W-1];
    end else begin
      fits = 1'b1;
    end
    bad = quo[W] | !fits;

    if (mode.rem) begin
      if (mode.half && mode.sgn) val = {{HW{rs[HW-1]}}, rs[HW-1:0]};
      else if (mode.sgn)         val = rs;
      else                       val = rmd;
    end else begin
      if (mode.half && mode.sgn) val = {{HW{1'b0}}, qs[HW-1:0]};
      else if (mode.sgn)         val = qs;
      else                       val = q;
    end

    res = bad ? '0 : val;
    if (res == '0)      crw = CRF_EQ;
    else if (res[W-1])  crw = CRF_LT;
    else                crw = CRF_GT;
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import idiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic           sgn_op,
  input  logic           half_op,
  input  logic           ext_op,
  input  logic           rem_op,
  input  logic           rec_op,
  output logic [W-1:0]   res_out,
  output logic [CRW-1:0] crf_out,
  output logic           res_valid,
  output logic           res_wen,
  output logic           crf_wen
);
  localparam int HW   = W / 2;
  localparam int ITER = W + 1;
  localparam int CW   = $clog2(ITER + 1);

  idiv_state_t    state;
  logic [CW-1:0]  cnt;
  idiv_mode_t     mode_in, mode_q;
  logic           negq_q, negr_q, negq_in, negr_in;
  logic           load, step;
  logic [2*W-1:0] dvd;
  logic [W-1:0]   dvs, rmd, fin_res;
  logic [W:0]     quo;
  logic [CRW-1:0] fin_crw;

  assign mode_in = '{sgn: sgn_op, half: half_op, ext: ext_op, rem: rem_op, rec: rec_op};
  assign load    = (state == ST_IDLE) && start;
  assign step    = (state == ST_RUN);

  idiv_prep #(.W(W)) u_prep (
    .opa(opa), .opb(opb), .mode(mode_in),
    .dvd(dvd), .dvs(dvs), .neg_q(negq_in), .neg_r(negr_in)
  );

  idiv_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .dvd(dvd), .dvs(dvs), .quo(quo), .rmd(rmd)
  );

  idiv_post #(.W(W)) u_post (
    .quo(quo), .rmd(rmd), .mode(mode_q), .neg_q(negq_q), .neg_r(negr_q),
    .res(fin_res), .crw(fin_crw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      mode_q <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_RUN;
          cnt    <= '0;
          mode_q <= mode_in;
          negq_q <= negq_in;
          negr_q <= negr_in;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ITER - 1)) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      crf_out   <= '0;
      res_valid <= 1'b0;
      res_wen   <= 1'b0;
      crf_wen   <= 1'b0;
    end else if (state == ST_FIN) begin
      res_out   <= fin_res;
      crf_out   <= fin_crw;
      res_valid <= 1'b1;
      res_wen   <= 1'b1;
      crf_wen   <= mode_q.rec & ~mode_q.rem;
    end else begin
      res_valid <= 1'b0;
      res_wen   <= 1'b0;
      crf_wen   <= 1'b0;
    end
  end

  // latency observer for the strobe-timing property
  logic [CW:0] since_load;
  always_ff @(posedge clk) begin
    if (rst)                      since_load <= '0;
    else if (load)                since_load <= '0;
    else if (state != ST_IDLE)    since_load <= since_load + 1'b1;
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R10
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (since_load == (CW+1)'(ITER + 1))); // R10
  AST_CRF_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($onehot(crf_out) && ((res_out == '0) == (crf_out == CRF_EQ)))); // R8
  AST_CRF_WEN_GATED: assert property (@(posedge clk) disable iff (rst)
    crf_wen |-> (res_wen && res_valid && !mode_q.rem && mode_q.rec)); // R9
  AST_HALF_SGN_UPPER: assert property (@(posedge clk) disable iff (rst)
    (res_valid && mode_q.half && mode_q.sgn && !mode_q.rem) |-> (res_out[W-1:HW] == '0)); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(mode_q)); // R11
endmodule

// File: tb/iter_divider_tb.sv
module iter_divider_tb;
  localparam int W = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  opa = '0, opb = '0;
  logic          sgn_op = 0, half_op = 0, ext_op = 0, rem_op = 0, rec_op = 0;
  logic [W-1:0]  res_out;
  logic [31:0]   crf_out;
  logic          res_valid, res_wen, crf_wen;

  iter_divider #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .opa(opa), .opb(opb),
    .sgn_op(sgn_op), .half_op(half_op), .ext_op(ext_op), .rem_op(rem_op), .rec_op(rec_op),
    .res_out(res_out), .crf_out(crf_out), .res_valid(res_valid),
    .res_wen(res_wen), .crf_wen(crf_wen)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string cur_tag = "R1";

  // reference state
  bit          mbusy = 0;
  int          mcnt  = 0;
  bit          ref_valid = 0;
  logic [63:0] ref_res = '0, pend_res;
  logic [31:0] ref_cr = '0, pend_cr;
  bit          ref_cren = 0, pend_cren;
  string       ref_tag = "R1", pend_tag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input bit s, input bit h, input bit e, input bit m, input bit rc,
                                output logic [63:0] res, output logic [31:0] cr, output bit cren);
    logic [127:0] ea, eb, ma, mb, n, q, r, lim;
    logic [63:0]  v;
    bit sa, sb, neg, bad;
    int w;
    w = h ? 32 : 64;
    if (h) begin
      ea = s ? {{96{a[31]}}, a[31:0]} : {96'b0, a[31:0]};
      eb = s ? {{96{b[31]}}, b[31:0]} : {96'b0, b[31:0]};
    end else begin
      ea = s ? {{64{a[63]}}, a} : {64'b0, a};
      eb = s ? {{64{b[63]}}, b} : {64'b0, b};
    end
    sa = s && ea[127];
    sb = s && eb[127];
    ma = sa ? -ea : ea;
    mb = sb ? -eb : eb;
    n  = e ? (ma << w) : ma;
    neg = sa ^ sb;
    if (mb == 0) begin q = 0; r = 0; bad = 1; end
    else begin q = n / mb; r = n % mb; bad = 0; end
    if (!m) begin
      if (s) lim = neg ? (128'd1 << (w-1)) : ((128'd1 << (w-1)) - 1);
      else   lim = (128'd1 << w) - 1;
      if (q > lim) bad = 1;
      v = neg ? -q[63:0] : q[63:0];
      if (h && s) v = {32'b0, v[31:0]};
    end else begin
      if (n >= (mb << 64)) bad = 1;
      v = sa ? -r[63:0] : r[63:0];
      if (h && s) v = {{32{v[31]}}, v[31:0]};
    end
    res  = bad ? 64'd0 : v;
    cr   = (res == 0) ? 32'h2000_0000 : (res[63] ? 32'h8000_0000 : 32'h4000_0000);
    cren = rc && !m;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mbusy = 0; ref_valid = 0;
    end else begin
      ref_valid = 0;
      if (mbusy) begin
        mcnt++;
        if (mcnt == W + 2) begin
          ref_valid = 1; mbusy = 0;
          ref_res = pend_res; ref_cr = pend_cr; ref_cren = pend_cren; ref_tag = pend_tag;
        end
      end else if (start) begin
        mbusy = 1; mcnt = 0;
        model(opa, opb, sgn_op, half_op, ext_op, rem_op, rec_op, pend_res, pend_cr, pend_cren);
        pend_tag = cur_tag;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(res_valid == ref_valid, "R10", "valid", 64'(res_valid), 64'(ref_valid));
      if (ref_valid) begin
        chk(res_out == ref_res, ref_tag, "result", res_out, ref_res);
        chk(crf_out == ref_cr, (ref_cr == 32'h2000_0000) ? ref_tag : "R8", "cond", 64'(crf_out), 64'(ref_cr));
        chk(res_wen == 1'b1, "R9", "res_wen", 64'(res_wen), 64'd1);
        chk(crf_wen == ref_cren, "R9", "crf_wen", 64'(crf_wen), 64'(ref_cren));
      end
    end
  end

  task automatic drive(input logic [63:0] a, input logic [63:0] b,
                       input bit s, input bit h, input bit e, input bit m, input bit rc);
    opa = a; opb = b; sgn_op = s; half_op = h; ext_op = e; rem_op = m; rec_op = rc;
  endtask

  task automatic do_op(input logic [63:0] a, input logic [63:0] b,
                       input bit s, input bit h, input bit e, input bit m, input bit rc,
                       input string tag);
    @(negedge clk);
    cur_tag = tag;
    drive(a, b, s, h, e, m, rc);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (W + 3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 0 && res_wen == 0 && crf_wen == 0, "R12", "flags in reset", {61'b0, res_valid, res_wen, crf_wen}, 64'd0);
    rst = 0;
    @(negedge clk);
    chk(res_valid == 0 && res_out == 0, "R12", "after reset", res_out, 64'd0);

    // R1 unsigned
    do_op(64'd100, 64'd7, 0, 0, 0, 0, 1, "R1");
    do_op(64'd100, 64'd7, 0, 0, 0, 1, 1, "R1");
    do_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 1, "R1");
    // R2 signed
    do_op(-64'sd100, 64'd7, 1, 0, 0, 0, 1, "R2");
    do_op(-64'sd100, 64'd7, 1, 0, 0, 1, 0, "R2");
    do_op(64'd100, -64'sd7, 1, 0, 0, 1, 0, "R2");
    do_op(-64'sd100, -64'sd7, 1, 0, 0, 0, 1, "R2");
    // R3 extended
    do_op(64'd1, 64'd3, 0, 0, 1, 0, 1, "R3");
    do_op(64'd1, 64'd3, 0, 1, 1, 0, 1, "R3");
    do_op(64'd3, 64'd3, 0, 0, 1, 0, 1, "R4");
    // R4 divide by zero
    do_op(64'd55, 64'd0, 0, 0, 0, 0, 1, "R4");
    do_op(64'd55, 64'd0, 1, 1, 0, 1, 0, "R4");
    // R5 range
    do_op(64'h8000_0000_0000_0000, -64'sd1, 1, 0, 0, 0, 1, "R5");
    do_op(64'h0000_0000_8000_0000, 64'hFFFF_FFFF, 1, 1, 0, 0, 1, "R5");
    do_op(64'd1, 64'd1, 0, 1, 1, 0, 1, "R5");
    do_op(64'h8000_0000_0000_0000, 64'd1, 1, 0, 0, 0, 1, "R5");
    // R6 half signed quotient
    do_op(64'h0000_0000_FFFF_FFF0, 64'd4, 1, 1, 0, 0, 1, "R6");
    // R7 half signed remainder negative
    do_op(64'h0000_0000_FFFF_FFEF, 64'd5, 1, 1, 0, 1, 1, "R7");
    // R8 zero result, R9 gating
    do_op(64'd3, 64'd9, 0, 0, 0, 0, 1, "R8");
    do_op(64'd9, 64'd4, 0, 0, 0, 1, 1, "R9");
    do_op(64'd9, 64'd4, 0, 0, 0, 0, 0, "R9");

    // R11 start during busy is ignored
    @(negedge clk);
    cur_tag = "R11";
    drive(64'd1000, 64'd10, 0, 0, 0, 0, 1);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    drive(64'd77, 64'd2, 1, 1, 0, 1, 0);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (W + 3) @(negedge clk);

    // mixed patterns
    for (int i = 0; i < 60; i++) begin
      logic [63:0] a, b;
      bit s, h, e, m;
      a = {$urandom, $urandom};
      b = (i % 3 == 0) ? 64'($urandom % 50) : {$urandom % 8, $urandom};
      s = i[0]; h = i[1]; e = (i % 5 == 0); m = i[2];
      do_op(a, b, s, h, e, m, 1'b1, "R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule